// File: doc/BRIEF.md
# Nibble-Loaded Bank Register File

This block is the write-side decode and register file of a cartridge memory mapper attached to an 8-bit CPU bus. Eleven 8-bit bank numbers are held here. Three of them pick the 8 KB program-ROM windows at CPU 0x8000, 0xA000 and 0xC000. The other eight pick the 1 KB character-ROM windows. A separate 2-bit field holds the nametable mirroring mode. The window at 0xE000 always shows the last program bank, and that bank number is a constant output derived from a parameter.

A bank register cannot be loaded as a whole byte in one write. Each register owns an even/odd pair of addresses. A write to the even address replaces the low nibble, a write to the odd address replaces the high nibble, and only data bits 3:0 are used. Downstream address translation reads the bank outputs directly; they come straight from the registers.

Top module: `nib_bank_regfile`

## Requirements
- R1: After reset, the program bank registers for windows 0x8000 and 0xA000 and all eight character bank registers are 0, and the mirroring mode is 0.
- R2: After reset, the program bank for window 0xC000 is PRG_BANKS-2. The fixed output `prg_last` always equals PRG_BANKS-1.
- R3: A write to the even address of a pair sets bits 3:0 of that register to data bits 3:0 and leaves bits 7:4 unchanged.
- R4: A write to the odd address of a pair sets bits 7:4 of that register to data bits 3:0 and leaves bits 3:0 unchanged. Data bits 7:4 are ignored on every register write.
- R5: Program bank pairs: the 0x8000 window uses 0x8000/0x8001, the 0xA000 window uses 0x8002/0x8003, and the 0xC000 window uses 0x9000/0x9001.
- R6: Character bank k (k=0..7) uses the pair at base 0xA000 + 0x1000*(k/2) + 2*(k%2), with the odd address being base+1.
- R7: A write to 0xF002 sets the mirroring mode to data bits 1:0, where 0 means horizontal, 1 means vertical, and 2 or 3 mean four-screen. The output `mirror_mode` carries the raw code.
- R8: A write to any other address, including 0xE000-0xE003, 0xF000 and 0xF001, changes no register.
- R9: Registers change only on a rising clock edge with `wr_en` high. The new value appears on the outputs right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | CPU write strobe |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| prg_bank | output | 24 | Program banks; bits 8i+7:8i hold window i (0x8000, 0xA000, 0xC000) |
| chr_bank | output | 64 | Character banks; bits 8k+7:8k hold 1 KB window k |
| prg_last | output | 8 | Fixed bank for the 0xE000 window |
| mirror_mode | output | 2 | Mirroring code |

## Verification
Embedded assertions check every cycle that no register moves without a decoded write to it, that a nibble write leaves the other nibble intact, that the fixed output is constant, and that at most one register is selected. Per-address placement, the parameter-derived reset values, rejection of the interrupt-control addresses and whole sequences of nibble writes are shown only by the bench's reference model, which mirrors the register file in plain arrays and compares all outputs on every clock.

// File: rtl/nib_bank_pkg.sv
package nib_bank_pkg;
  localparam int NUM_PRG   = 3;
  localparam int NUM_CHR   = 8;
  localparam int NUM_BANK  = NUM_PRG + NUM_CHR;
  localparam int BANK_W    = 8;
  localparam int NIB_W     = 4;
  localparam int ADDR_W    = 16;
  localparam int MIR_W     = 2;
  localparam logic [ADDR_W-1:0] MIRROR_ADDR = 16'hF002;

  // Even address of the nibble pair for bank index b (0..2 program, 3..10 character)
  function automatic logic [ADDR_W-1:0] pair_base(input int b);
    logic [ADDR_W-1:0] a;
    if (b < 2)            a = 16'h8000 + 16'(2*b);
    else if (b == 2)      a = 16'h9000;
    else                  a = 16'hA000 + 16'(16'h1000*((b-3)/2)) + 16'(2*((b-3)%2));
    return a;
  endfunction
endpackage

// File: rtl/nib_addr_decode.sv
module nib_addr_decode
  import nib_bank_pkg::*;
(
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic [NUM_BANK-1:0] sel_lo,
  output logic [NUM_BANK-1:0] sel_hi,
  output logic              sel_mir
);
  for (genvar b = 0; b < NUM_BANK; b++) begin : g_dec
    localparam logic [ADDR_W-1:0] BASE = pair_base(b);
    always_comb begin
      sel_lo[b] = wr_en && (wr_addr == BASE);
      sel_hi[b] = wr_en && (wr_addr == (BASE | 16'h0001));
    end
  end

  always_comb sel_mir = wr_en && (wr_addr == MIRROR_ADDR);
endmodule

// File: rtl/nib_bank_reg.sv
module nib_bank_reg
  import nib_bank_pkg::*;
#(
  parameter logic [BANK_W-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_lo,
  input  logic              ld_hi,
  input  logic [NIB_W-1:0]  nib,
  output logic [BANK_W-1:0] q
);
  logic [BANK_W-1:0] q_nxt;
  logic              q_en;

  always_comb begin
    q_en  = ld_lo | ld_hi;
    q_nxt = q;
    if (ld_lo) q_nxt[NIB_W-1:0]      = nib;
    if (ld_hi) q_nxt[BANK_W-1:NIB_W] = nib;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= RST_VAL;
    else if (q_en) q <= q_nxt;
  end

  // R9: no change without a load
  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_lo || ld_hi) |=> $stable(q));
  // R3: low load keeps high nibble
  p_lo_keeps_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_lo && !ld_hi) |=> (q[BANK_W-1:NIB_W] == $past(q[BANK_W-1:NIB_W])) && (q[NIB_W-1:0] == $past(nib)));
  // R4: high load keeps low nibble
  p_hi_keeps_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_hi && !ld_lo) |=> (q[NIB_W-1:0] == $past(q[NIB_W-1:0])) && (q[BANK_W-1:NIB_W] == $past(nib)));
endmodule

// File: rtl/nib_bank_regfile.sv
module nib_bank_regfile
  import nib_bank_pkg::*;
#(
  parameter int PRG_BANKS = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [BANK_W-1:0]           wr_data,
  output logic [NUM_PRG*BANK_W-1:0]   prg_bank,
  output logic [NUM_CHR*BANK_W-1:0]   chr_bank,
  output logic [BANK_W-1:0]           prg_last,
  output logic [MIR_W-1:0]            mirror_mode
);
  localparam logic [BANK_W-1:0] LAST_BANK = BANK_W'(PRG_BANKS - 1);
  localparam logic [BANK_W-1:0] PENULT    = BANK_W'(PRG_BANKS - 2);

  logic [NUM_BANK-1:0] sel_lo, sel_hi;
  logic                sel_mir;
  logic [BANK_W-1:0]   bank_q [NUM_BANK];
  logic [MIR_W-1:0]    mir_q, mir_nxt;

  nib_addr_decode u_dec (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .sel_lo  (sel_lo),
    .sel_hi  (sel_hi),
    .sel_mir (sel_mir)
  );

  for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
    localparam logic [BANK_W-1:0] RV = (b == 2) ? PENULT : '0;
    nib_bank_reg #(.RST_VAL(RV)) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .ld_lo (sel_lo[b]),
      .ld_hi (sel_hi[b]),
      .nib   (wr_data[NIB_W-1:0]),
      .q     (bank_q[b])
    );
    if (b < NUM_PRG) begin : g_prg
      assign prg_bank[b*BANK_W +: BANK_W] = bank_q[b];
    end else begin : g_chr
      assign chr_bank[(b-NUM_PRG)*BANK_W +: BANK_W] = bank_q[b];
    end
  end

  always_comb begin
    mir_nxt = mir_q;
    if (sel_mir) mir_nxt = wr_data[MIR_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mir_q <= '0;
    else if (sel_mir) mir_q <= mir_nxt;
  end

  assign mirror_mode = mir_q;
  assign prg_last    = LAST_BANK;

  // R8: at most one target per write
  p_one_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({sel_lo, sel_hi, sel_mir}) <= 1);
  // R7: mirroring moves only on its own address
  p_mirror_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == MIRROR_ADDR) |=> $stable(mirror_mode));
  // R2: fixed bank constant
  p_last_fixed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    prg_last == BANK_W'(PRG_BANKS - 1));
endmodule

// File: tb/nib_bank_regfile_bench.sv
`timescale 1ns/1ps
module nib_bank_regfile_bench;
  localparam int PRG_BANKS = 16;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [15:0] wr_addr = 0;
  logic [7:0]  wr_data = 0;
  logic [23:0] prg_bank;
  logic [63:0] chr_bank;
  logic [7:0]  prg_last;
  logic [1:0]  mirror_mode;
  int n_cmp = 0, n_bad = 0;
  int m_bank [11];
  int m_mir;
  bit cmp_on = 0;

  always #10 clk = ~clk;

  nib_bank_regfile #(.PRG_BANKS(PRG_BANKS)) u_nib_bank_regfile (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .prg_bank(prg_bank), .chr_bank(chr_bank), .prg_last(prg_last), .mirror_mode(mirror_mode));

  function automatic int addr_of(int b);
    if (b < 2) return 'h8000 + 2*b;
    if (b == 2) return 'h9000;
    return 'hA000 + 'h1000*((b-3)/2) + 2*((b-3)%2);
  endfunction

  task automatic model_reset();
    for (int b = 0; b < 11; b++) m_bank[b] = 0;
    m_bank[2] = PRG_BANKS - 2;
    m_mir = 0;
  endtask

  task automatic model_write(int a, int d);
    for (int b = 0; b < 11; b++) begin
      if (a == addr_of(b))     m_bank[b] = (m_bank[b] & 'hF0) | (d & 'h0F);
      if (a == addr_of(b) + 1) m_bank[b] = (m_bank[b] & 'h0F) | ((d & 'h0F) << 4);
    end
    if (a == 'hF002) m_mir = d & 3;
  endtask

  task automatic compare(string tag);
    n_cmp++;
    for (int b = 0; b < 11; b++) begin
      int act;
      act = (b < 3) ? int'(prg_bank[b*8 +: 8]) : int'(chr_bank[(b-3)*8 +: 8]);
      if (act != m_bank[b]) begin
        n_bad++;
        $display("FAIL %s bank%0d actual=%0h expected=%0h", tag, b, act, m_bank[b]);
      end
    end
    if (int'(mirror_mode) != m_mir) begin
      n_bad++; $display("FAIL R7 mirror actual=%0d expected=%0d", mirror_mode, m_mir);
    end
    if (int'(prg_last) != PRG_BANKS - 1) begin
      n_bad++; $display("FAIL R2 last actual=%0d expected=%0d", prg_last, PRG_BANKS-1);
    end
  endtask

  // compare on every clock, at the falling edge
  always @(negedge clk) if (cmp_on) compare("R9");

  task automatic wr(int a, int d, bit en = 1);
    wr_addr = 16'(a); wr_data = 8'(d); wr_en = en;
    @(posedge clk);
    if (en) model_write(a, d);
    #1 wr_en = 0;
  endtask

  initial begin
    model_reset();
    #25;
    compare("R1"); compare("R2");
    @(negedge clk) rst_n = 1;
    cmp_on = 1;
    // R3/R4/R5: program pairs, high data nibble ignored
    wr('h8000, 'hA5); wr('h8001, 'h3C);
    wr('h8002, 'h07); wr('h8003, 'hF9);
    wr('h9000, 'h1E); wr('h9001, 'h02);
    // R6: every character pair
    for (int k = 0; k < 8; k++) begin
      wr(addr_of(k+3), k + 'h10); wr(addr_of(k+3) + 1, 15 - k);
    end
    // R3: rewrite low only
    wr(addr_of(5), 'h4);
    // R7: all mirror codes
    for (int m = 0; m < 4; m++) wr('hF002, 'hFC | m);
    wr('hF002, 1);
    // R8: unlisted addresses
    wr('hE000, 'hF); wr('hE003, 7); wr('hF000, 1); wr('hF001, 3);
    wr('hF003, 2); wr('h8004, 9); wr('h9002, 9); wr('hA004, 9); wr('h0000, 9);
    // R9: strobe low does nothing
    wr('h8000, 'hB, 0); wr('hF002, 2, 0);
    repeat (3) @(posedge clk);
    // R1: reset again mid-run
    @(negedge clk) rst_n = 0; #1 model_reset();
    @(negedge clk); @(negedge clk) rst_n = 1;
    wr('hD003, 'h6);
    repeat (2) @(posedge clk);
    cmp_on = 0;
    #5;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule